// File: doc/BRIEF.md
# Single-Error Sector Code Checker and Corrector

This block judges one 512-byte sector read back from flash storage. It compares two 24-bit check codes: the code saved with the sector and the code computed again from the data as it was read. It sorts the result into four outcomes: clean, a single data bit to repair, damage inside the saved code only, or beyond repair. For a repairable data bit it gives the byte offset inside the sector and a one-hot bit mask. The caller XORs that mask into the stored byte.

The check code holds twelve parity bits together with their twelve complements. A single flipped data bit therefore leaves a difference whose upper and lower twelve bits are exact complements of each other. The upper half of that difference then gives the byte offset and the bit number.

The block also turns a raw 32-bit parity word from the accumulator into the 24-bit saved form. It drops the reserved nibbles and inverts the result, so that an erased page, which reads as all ones, checks as clean. Byte 0 of the stored code is bits 7:0, byte 1 is bits 15:8 and byte 2 is bits 23:16.

Top module: `hecc_corrector`

## Requirements
- R1: `foldCode` equals the bitwise inverse of {rawParity[27:16], rawParity[11:0]}. It is combinational, and rawParity bits 31:28 and 15:12 have no effect on it.
- R2: A raw parity word of zero folds to 24'hFFFFFF, so an erased page carries a code that matches itself.
- R3: The difference is storedCode XOR calcCode. A zero difference gives status 0 (clean), with byte index 0 and mask 0.
- R4: When the upper 12 bits of the difference XOR the lower 12 bits equal 12'hFFF, and the byte index is in range, the status is 1 (corrected). The byte index is difference bits 23:15, and the mask is one-hot with bit difference[14:12] set.
- R5: If that complement pattern gives a byte index not below the parameter SECTOR_BYTES, the status is 3 (uncorrectable), with byte index and mask 0.
- R6: A difference with exactly one bit set gives status 2 (error in the code only), with byte index 0 and mask 0.
- R7: Any other nonzero difference gives status 3 (uncorrectable), with byte index and mask 0.
- R8: `outValid` pulses one clock after each cycle in which `inValid` is high. The results are registered on that edge and hold until the next accepted input.
- R9: While `rst_n` is low, `outValid`, `outStatus`, `outByte` and `outMask` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Code pair on storedCode/calcCode is presented this cycle |
| storedCode | input | 24 | Code saved with the sector |
| calcCode | input | 24 | Code computed from the data as read |
| rawParity | input | 32 | Raw parity word from the accumulator |
| foldCode | output | 24 | Inverted 24-bit code formed from rawParity |
| outValid | output | 1 | Result strobe |
| outStatus | output | 2 | 0 clean, 1 corrected, 2 code-only error, 3 uncorrectable |
| outByte | output | 9 | Byte offset of the bad bit |
| outMask | output | 8 | One-hot mask to XOR into that byte |

## Verification
The assertions compare each result with the code pair captured one cycle earlier. They therefore assume that storedCode and calcCode carry defined values whenever inValid is high, and that a strobe is followed by a result cycle before the pair is read again. The stimulus changes inputs only on the falling edge and raises inValid for one cycle at a time. It reads each result before presenting the next pair. A second instance built with a smaller sector size covers the out-of-range offset case, which the default size cannot reach.

// File: rtl/hecc_pkg.sv
package hecc_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN   = 2'd0,
    ST_FIXED   = 2'd1,
    ST_CODEERR = 2'd2,
    ST_BAD     = 2'd3
  } hecc_status_e;

  typedef struct packed {
    logic capture;
  } hecc_ctrl_t;
endpackage

// File: rtl/hecc_ctrl.sv
module hecc_ctrl
  import hecc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  output hecc_ctrl_t ctl,
  output logic       outValid
);
  always_comb ctl.capture = inValid;

  always_ff @(posedge clk) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end
endmodule

// File: rtl/hecc_datapath.sv
module hecc_datapath
  import hecc_pkg::*;
#(
  parameter int CODE_W       = 24,
  parameter int RAW_W        = 32,
  parameter int SECTOR_BYTES = 512
) (
  input  logic                clk,
  input  logic                rst_n,
  input  hecc_ctrl_t          ctl,
  input  logic [CODE_W-1:0]   storedCode,
  input  logic [CODE_W-1:0]   calcCode,
  input  logic [RAW_W-1:0]    rawParity,
  output logic [CODE_W-1:0]   foldCode,
  output logic [1:0]          outStatus,
  output logic [CODE_W/2-4:0] outByte,
  output logic [7:0]          outMask
);
  localparam int HALF_W  = CODE_W / 2;
  localparam int SEL_W   = 3;
  localparam int LANES   = 1 << SEL_W;
  localparam int IDX_W   = HALF_W - SEL_W;
  localparam int RAW_HI  = RAW_W / 2;

  // parity word folding: drop reserved nibbles, invert
  logic unusedReserved;
  always_comb begin
    foldCode = ~{rawParity[RAW_HI+HALF_W-1:RAW_HI], rawParity[HALF_W-1:0]};
    unusedReserved = ^{rawParity[RAW_W-1:RAW_HI+HALF_W], rawParity[RAW_HI-1:HALF_W]};
  end

  logic [CODE_W-1:0] diff;
  logic [HALF_W-1:0] hiHalf, loHalf;
  logic [IDX_W-1:0]  byteIdx;
  logic [SEL_W-1:0]  bitSel;
  logic              isPair, inRange, isSingle;
  logic [LANES-1:0]  maskNext;

  always_comb begin
    diff     = storedCode ^ calcCode;
    hiHalf   = diff[CODE_W-1:HALF_W];
    loHalf   = diff[HALF_W-1:0];
    isPair   = (hiHalf ^ loHalf) == {HALF_W{1'b1}};
    byteIdx  = diff[CODE_W-1:HALF_W+SEL_W];
    bitSel   = diff[HALF_W+SEL_W-1:HALF_W];
    inRange  = 32'(byteIdx) < SECTOR_BYTES;
    isSingle = (diff != '0) && ((diff & (diff - 1'b1)) == '0);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign maskNext[g] = (bitSel == SEL_W'(g));
  end

  hecc_status_e statusNext;
  logic [IDX_W-1:0] byteNext;
  logic [LANES-1:0] maskSel;

  always_comb begin
    statusNext = ST_BAD;
    byteNext   = '0;
    maskSel    = '0;
    if (diff == '0) begin
      statusNext = ST_CLEAN;
    end else if (isPair) begin
      if (inRange) begin
        statusNext = ST_FIXED;
        byteNext   = byteIdx;
        maskSel    = maskNext;
      end
    end else if (isSingle) begin
      statusNext = ST_CODEERR;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outStatus <= '0;
      outByte   <= '0;
      outMask   <= '0;
    end else if (ctl.capture) begin
      outStatus <= statusNext;
      outByte   <= byteNext;
      outMask   <= maskSel;
    end
  end
endmodule

// File: rtl/hecc_corrector.sv
module hecc_corrector
  import hecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic [23:0] storedCode,
  input  logic [23:0] calcCode,
  input  logic [31:0] rawParity,
  output logic [23:0] foldCode,
  output logic        outValid,
  output logic [1:0]  outStatus,
  output logic [8:0]  outByte,
  output logic [7:0]  outMask
);
  hecc_ctrl_t ctl;

  hecc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .ctl(ctl), .outValid(outValid)
  );

  hecc_datapath #(.CODE_W(24), .RAW_W(32), .SECTOR_BYTES(SECTOR_BYTES)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl),
    .storedCode(storedCode), .calcCode(calcCode), .rawParity(rawParity),
    .foldCode(foldCode), .outStatus(outStatus), .outByte(outByte), .outMask(outMask)
  );
endmodule

// File: rtl/hecc_corrector_chk.sv
module hecc_corrector_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        inValid,
  input logic [23:0] storedCode,
  input logic [23:0] calcCode,
  input logic        outValid,
  input logic [1:0]  outStatus,
  input logic [8:0]  outByte,
  input logic [7:0]  outMask
);
  a_r8_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> $past(inValid));
  a_r3_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && $past(storedCode == calcCode)) |-> (outStatus == 2'd0));
  a_r6_code_only: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && ($countones($past(storedCode ^ calcCode)) == 1)) |-> (outStatus == 2'd2));
  a_r4_mask_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outStatus == 2'd1) |-> ($countones(outMask) == 1));
  a_r7_fields_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outStatus != 2'd1) |-> (outMask == 8'd0 && outByte == 9'd0));
endmodule

bind hecc_corrector hecc_corrector_chk u_chk (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .storedCode(storedCode),
  .calcCode(calcCode), .outValid(outValid), .outStatus(outStatus),
  .outByte(outByte), .outMask(outMask)
);

// File: tb/hecc_corrector_test.sv
module hecc_corrector_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic [23:0] storedCode = '0, calcCode = '0;
  logic [31:0] rawParity = '0;
  logic [23:0] foldCode, foldSmall;
  logic outValid, validSmall;
  logic [1:0] outStatus, statusSmall;
  logic [8:0] outByte, byteSmall;
  logic [7:0] outMask, maskSmall;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  hecc_corrector uut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .storedCode(storedCode),
    .calcCode(calcCode), .rawParity(rawParity), .foldCode(foldCode),
    .outValid(outValid), .outStatus(outStatus), .outByte(outByte), .outMask(outMask)
  );

  hecc_corrector #(.SECTOR_BYTES(256)) uutSmall (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .storedCode(storedCode),
    .calcCode(calcCode), .rawParity(rawParity), .foldCode(foldSmall),
    .outValid(validSmall), .outStatus(statusSmall), .outByte(byteSmall), .outMask(maskSmall)
  );

  // stored, calc, status, byte, mask
  localparam int NV = 9;
  localparam logic [66:0] VEC [NV] = '{
    {24'h123456, 24'h123456, 2'd0, 9'd0,   8'h00},  // R3
    {24'h000000, 24'h02AFD5, 2'd1, 9'd5,   8'h04},  // R4
    {24'hFFFFFF, 24'h000FFF, 2'd1, 9'd511, 8'h80},  // R4 top byte
    {24'h00ABCD, 24'h00A432, 2'd1, 9'd0,   8'h01},  // R4 byte 0
    {24'h111111, 24'h87278D, 2'd1, 9'd300, 8'h08},  // R4
    {24'h800001, 24'h000001, 2'd2, 9'd0,   8'h00},  // R6 msb
    {24'h000000, 24'h000001, 2'd2, 9'd0,   8'h00},  // R6 lsb
    {24'h000000, 24'h000003, 2'd3, 9'd0,   8'h00},  // R7
    {24'h000000, 24'hFFFFFF, 2'd3, 9'd0,   8'h00}   // R7
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [23:0] s, input logic [23:0] c);
    @(negedge clk);
    storedCode = s; calcCode = c; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 valid", outValid, 0);
    check("R9 status", outStatus, 0);
    check("R9 byte", outByte, 0);
    check("R9 mask", outMask, 0);
    rst_n = 1'b1;

    // R1/R2 folding
    rawParity = 32'h0; #1;
    check("R2 erased fold", foldCode, 24'hFFFFFF);
    rawParity = 32'hF000F000; #1;
    check("R1 reserved ignored", foldCode, 24'hFFFFFF);
    rawParity = 32'h0ABC0123; #1;
    check("R1 fold", foldCode, 24'h543EDC);
    rawParity = 32'hFFFFFFFF; #1;
    check("R1 fold ones", foldCode, 24'h000000);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][66:43], VEC[i][42:19]);
      check("R8 strobe", outValid, 1);
      check("R3-7 status", outStatus, int'(VEC[i][18:17]));
      check("R4 byte", outByte, int'(VEC[i][16:8]));
      check("R4 mask", outMask, int'(VEC[i][7:0]));
    end

    // R8: strobe drops, result holds
    @(negedge clk);
    check("R8 strobe low", outValid, 0);
    check("R8 hold status", outStatus, 3);

    // R5 on small-sector instance: offset 300 out of range
    apply(24'h111111, 24'h87278D);
    check("R5 status", statusSmall, 3);
    check("R5 byte", byteSmall, 0);
    check("R5 mask", maskSmall, 0);
    check("R5 default in range", outStatus, 1);
    apply(24'h000000, 24'h02AFD5);
    check("R5 small in range", statusSmall, 1);
    check("R5 small byte", byteSmall, 5);

    // R9 reset after activity
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 status after", outStatus, 0);
    check("R9 mask after", outMask, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule